// File: doc/BRIEF.md
# Seven-Segment Search Decoder

This block recovers the decimal digit shown on one seven-segment LCD position without decoding the segment pattern directly. An internal decimal counter drives a digit-to-segment encoder, and the encoder's lines are inverted with the backplane in the same way the panel's own drive inverts them. The re-encoded lines are compared with the segment lines actually seen. While they differ, the counter steps on. When every segment agrees, the counter stops, and its value is the recovered digit.

The backplane and segment lines swap level on every backplane transition, and the segment lines can lag or lead the backplane by a few clocks. Comparisons therefore happen only in a window that opens a fixed number of clocks after each backplane change. A candidate becomes the output only once it has matched in two consecutive windows, which cover both backplane levels. If a complete pass over all ten candidates finds nothing, a flag reports that the shown glyph is not a digit. Response time is not a concern: the search may take many clocks, and confirmation takes a full backplane period.

Top module: `seg_seek`

## Requirements
- R1: When `rst_n` is low at a clock edge, `digit_out` becomes 0 and both `valid_out` and `nomatch_out` become 0.
- R2: The segment bus `seg_in` is ordered [6]=a (top), [5]=b (upper right), [4]=c (lower right), [3]=d (bottom), [2]=e (lower left), [1]=f (upper left), [0]=g (middle). A lit segment's line is at the opposite level to `bp_in`. An unlit segment's line is at the same level as `bp_in`.
- R3: The encoder uses this font, with segments listed as letters: 0=abcdef, 1=bc, 2=abdeg, 3=abcdg, 4=bcfg, 5=acdfg, 6=acdefg, 7=abc, 8=abcdefg, 9=abcdfg. In this font, 6 carries the top tail and 9 carries the bottom tail.
- R4: Each time a compare is made in the search phase and fails, the candidate advances by one, and it wraps from 9 to 0. Outside a compare window, the candidate does not change.
- R5: A compare window opens SETTLE_CYC clocks after each change of `bp_in` and stays open until the next change. Segment values present only before the window opens have no effect on the outputs.
- R6: `valid_out` rises only after the same candidate has matched in two consecutive windows, one at each backplane level. After the first matching window alone, `valid_out` is still 0.
- R7: While `valid_out` is 1, any mismatch inside a window drops `valid_out` and restarts the search from the next candidate.
- R8: After ten consecutive failed compares, `nomatch_out` becomes 1 and `valid_out` stays 0. `nomatch_out` clears when a candidate next matches.
- R9: With TAIL_DC=1, the top segment is ignored when comparing against 6, and the bottom segment is ignored when comparing against 9. Tail-less 6 (cdefg) therefore decodes as 6, and tail-less 9 (abcfg) decodes as 9.
- R10: While locked, `digit_out` holds the matched value, and `valid_out` stays 1 for as long as the same digit is displayed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bp_in | input | 1 | Observed backplane (common) line |
| seg_in | input | 7 | Observed segment lines, a at bit 6 down to g at bit 0 |
| digit_out | output | 4 | Current candidate; this is the recovered digit while `valid_out` is 1 |
| valid_out | output | 1 | Candidate confirmed across a full backplane period |
| nomatch_out | output | 1 | A full pass over all ten candidates found no match |

## Verification
The hardest situation to reach is a false lock caused by edge skew. In that case the segment lines still carry the previous phase, or another glyph, for a few clocks after a backplane change, and that transient could match some other digit. The bench locks onto one digit and then, on every backplane change, drives the encoding of a different digit for fewer clocks than the settling delay before it restores the real glyph. It checks that `valid_out` never drops during those periods and that `digit_out` keeps its value. Non-digit glyphs and tail-less 6 and 9 are also shown, to reach the no-match flag and the don't-care path.

// File: rtl/seg_seek_pkg.sv
// Package: shared constants, types and font helpers for the segment search
// decoder. Assumes segment bit order a..g at bits 6..0.
package seg_seek_pkg;

    localparam int SEG_W   = 7;
    localparam int DIGITS  = 10;
    localparam int DIGIT_W = 4;

    typedef logic [SEG_W-1:0]   seg_vec_t;
    typedef logic [DIGIT_W-1:0] digit_t;

    typedef enum logic [1:0] {
        ST_SEEK    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_LOCKED  = 2'd2
    } seek_state_e;

    // Lit-segment pattern of a decimal digit; 6 and 9 carry tails.
    function automatic seg_vec_t glyph_of(input digit_t d);
        case (d)
            4'd0:    glyph_of = 7'b1111110;
            4'd1:    glyph_of = 7'b0110000;
            4'd2:    glyph_of = 7'b1101101;
            4'd3:    glyph_of = 7'b1111001;
            4'd4:    glyph_of = 7'b0110011;
            4'd5:    glyph_of = 7'b1011011;
            4'd6:    glyph_of = 7'b1011111;
            4'd7:    glyph_of = 7'b1110000;
            4'd8:    glyph_of = 7'b1111111;
            4'd9:    glyph_of = 7'b1111011;
            default: glyph_of = 7'b0000000;
        endcase
    endfunction

    // Successor of a candidate, wrapping at the last digit.
    function automatic digit_t next_digit(input digit_t d);
        next_digit = (d == digit_t'(DIGITS - 1)) ? '0 : d + digit_t'(1);
    endfunction

endpackage

// File: rtl/seg_settle_timer.sv
// Settle timer: detects each backplane level change and opens a compare
// window SETTLE_CYC clocks later. The window stays open until the next
// change. Assumes SETTLE_CYC >= 1 and bp_in already in the clock domain.
module seg_settle_timer #(
    parameter int SETTLE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bp_in,
    output logic bp_phase,
    output logic win_open,
    output logic win_strobe
);
    localparam int TW = $clog2(SETTLE_CYC + 1);

    logic [TW-1:0] cnt_q;
    logic          open_q;
    logic          bp_edge;

    assign bp_edge    = (bp_in != bp_phase);
    assign win_open   = (cnt_q == '0) && !bp_edge;
    assign win_strobe = win_open && !open_q;

    // Track backplane level and restart the settle count on every change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp_phase <= 1'b0;
            cnt_q    <= TW'(SETTLE_CYC);
            open_q   <= 1'b0;
        end else begin
            bp_phase <= bp_in;
            open_q   <= win_open;
            if (bp_edge)
                cnt_q <= TW'(SETTLE_CYC);
            else if (cnt_q != '0)
                cnt_q <= cnt_q - TW'(1);
        end
    end

    // R5: the cycle after a backplane change is never inside a window.
    a_r5_closed_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        bp_edge |=> !win_open);

endmodule

// File: rtl/seg_encoder.sv
// Encoder: turns the candidate digit into the segment levels a panel driver
// would produce at the given backplane phase, plus a care mask. The mask
// drops the tail of 6 and 9 when TAIL_DC is set. Purely combinational.
module seg_encoder
    import seg_seek_pkg::*;
#(
    parameter bit TAIL_DC = 1'b1
) (
    input  digit_t   digit,
    input  logic     phase,
    output seg_vec_t drive,
    output seg_vec_t care
);
    // Lit segments sit at the level opposite the backplane.
    always_comb drive = glyph_of(digit) ^ {SEG_W{phase}};

    generate
        if (TAIL_DC) begin : g_tail_dc
            // Top segment ignored for 6, bottom segment ignored for 9.
            always_comb begin
                if (digit == digit_t'(6))      care = 7'b0111111;
                else if (digit == digit_t'(9)) care = 7'b1110111;
                else                           care = '1;
            end
        end else begin : g_tail_strict
            // Every segment is compared for every digit.
            always_comb care = '1;
        end
    endgenerate

endmodule

// File: rtl/seg_compare.sv
// Comparator: per-segment equality between the re-encoded levels and the
// observed lines, masked by care, reduced to one match bit.
module seg_compare
    import seg_seek_pkg::*;
(
    input  seg_vec_t drive,
    input  seg_vec_t care,
    input  seg_vec_t seg_obs,
    output logic     match
);
    seg_vec_t bit_ok;

    genvar i;
    generate
        for (i = 0; i < SEG_W; i++) begin : g_bit
            // One segment agrees, or it is a don't-care.
            assign bit_ok[i] = !care[i] || (drive[i] == seg_obs[i]);
        end
    endgenerate

    assign match = &bit_ok;

endmodule

// File: rtl/seg_search_fsm.sv
// Search controller: steps the candidate while windows show a mismatch,
// holds it on a match, confirms it in the following window and flags a
// full pass with no match. Acts only while the compare window is open.
module seg_search_fsm
    import seg_seek_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   win_open,
    input  logic   win_strobe,
    input  logic   match,
    output digit_t digit,
    output logic   locked,
    output logic   nomatch
);
    localparam int MW = $clog2(DIGITS + 1);

    seek_state_e   state_q;
    digit_t        digit_q;
    logic [MW-1:0] miss_q;
    logic          nomatch_q;

    // Search, confirm and lock sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_SEEK;
            digit_q   <= '0;
            miss_q    <= '0;
            nomatch_q <= 1'b0;
        end else begin
            case (state_q)
                ST_SEEK: begin
                    if (win_open) begin
                        if (match) begin
                            state_q   <= ST_CONFIRM;
                            miss_q    <= '0;
                            nomatch_q <= 1'b0;
                        end else begin
                            digit_q <= next_digit(digit_q);
                            if (miss_q != MW'(DIGITS))
                                miss_q <= miss_q + MW'(1);
                            if (miss_q >= MW'(DIGITS - 1))
                                nomatch_q <= 1'b1;
                        end
                    end
                end
                ST_CONFIRM: begin
                    if (win_strobe) begin
                        if (match) begin
                            state_q <= ST_LOCKED;
                        end else begin
                            state_q <= ST_SEEK;
                            digit_q <= next_digit(digit_q);
                            miss_q  <= MW'(1);
                        end
                    end
                end
                ST_LOCKED: begin
                    if (win_open && !match) begin
                        state_q <= ST_SEEK;
                        digit_q <= next_digit(digit_q);
                        miss_q  <= MW'(1);
                    end
                end
                default: state_q <= ST_SEEK;
            endcase
        end
    end

    assign digit   = digit_q;
    assign locked  = (state_q == ST_LOCKED);
    assign nomatch = nomatch_q;

    // R3: the candidate is always a decimal digit.
    a_r3_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
        digit_q <= digit_t'(DIGITS - 1));

    // R4: with no window open the candidate is frozen.
    a_r4_hold_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open |=> $stable(digit_q));

    // R4: a failed search compare steps the candidate by one, wrapping.
    a_r4_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && state_q == ST_SEEK && !match) |=>
        digit_q == (($past(digit_q) == digit_t'(DIGITS - 1)) ? digit_t'(0)
                                                             : $past(digit_q) + digit_t'(1)));

    // R6: lock can only begin at the start of a window.
    a_r6_lock_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_LOCKED && !win_strobe) |=> state_q != ST_LOCKED);

    // R8: the no-match flag never coexists with a lock.
    a_r8_nomatch_excl: assert property (@(posedge clk) disable iff (!rst_n)
        nomatch_q |-> state_q == ST_SEEK);

endmodule

// File: rtl/seg_seek.sv
// Top: segment search decoder for one LCD digit. Wires the settle timer,
// encoder, comparator and search controller. Assumes bp_in and seg_in are
// already level-shifted and in the clock domain.
module seg_seek
    import seg_seek_pkg::*;
#(
    parameter int SETTLE_CYC = 16,
    parameter bit TAIL_DC    = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bp_in,
    input  logic [6:0] seg_in,
    output logic [3:0] digit_out,
    output logic       valid_out,
    output logic       nomatch_out
);
    logic     bp_phase;
    logic     win_open;
    logic     win_strobe;
    logic     match;
    seg_vec_t drive;
    seg_vec_t care;
    digit_t   digit;

    seg_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .bp_in      (bp_in),
        .bp_phase   (bp_phase),
        .win_open   (win_open),
        .win_strobe (win_strobe)
    );

    seg_encoder #(.TAIL_DC(TAIL_DC)) u_enc (
        .digit (digit),
        .phase (bp_phase),
        .drive (drive),
        .care  (care)
    );

    seg_compare u_cmp (
        .drive   (drive),
        .care    (care),
        .seg_obs (seg_in),
        .match   (match)
    );

    seg_search_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_open   (win_open),
        .win_strobe (win_strobe),
        .match      (match),
        .digit      (digit),
        .locked     (valid_out),
        .nomatch    (nomatch_out)
    );

    assign digit_out = digit;

    // R10: while locked and outside a window, the reported digit holds.
    a_r10_locked_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && !win_open) |=> $stable(digit_out));

endmodule

// File: tb/tb_seg_seek.sv
// Bench: drives a panel-like backplane and segment waveform and sweeps
// all digits, non-digit glyphs, tail-less 6 and 9, and skewed edges.
module tb_seg_seek;
    localparam int SETTLE = 6;
    localparam int HP     = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bp_in = 1'b0;
    logic [6:0] seg_in = 7'd0;
    logic [3:0] digit_out;
    logic       valid_out;
    logic       nomatch_out;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    bit  bp_r = 1'b0;
    bit  saw_drop = 1'b0;
    int  saw_other = 0;

    always #2.5 clk = ~clk;

    seg_seek #(.SETTLE_CYC(SETTLE), .TAIL_DC(1'b1)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bp_in       (bp_in),
        .seg_in      (seg_in),
        .digit_out   (digit_out),
        .valid_out   (valid_out),
        .nomatch_out (nomatch_out)
    );

    // Font from R3, bit 6 = a ... bit 0 = g (R2).
    function automatic logic [6:0] font(input int d);
        case (d)
            0: font = 7'b1111110;  1: font = 7'b0110000;
            2: font = 7'b1101101;  3: font = 7'b1111001;
            4: font = 7'b0110011;  5: font = 7'b1011011;
            6: font = 7'b1011111;  7: font = 7'b1110000;
            8: font = 7'b1111111;  default: font = 7'b1111011;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One backplane half period showing lit; the first skew clocks show decoy.
    task automatic half(input logic [6:0] lit, input logic [6:0] decoy, input int skew);
        bp_r = ~bp_r;
        for (int i = 0; i < HP; i++) begin
            @(negedge clk);
            bp_in  = bp_r;
            seg_in = ((i < skew) ? decoy : lit) ^ {7{bp_r}};
            if (!valid_out) saw_drop = 1'b1;
            if (digit_out != saw_other[3:0]) saw_other = 99;
        end
    endtask

    // Show a glyph for a full period; check confirmation timing (R6).
    task automatic show_digit(input logic [6:0] lit, input int exp, input string req);
        half(lit, lit, 0);
        chk({req, " R6 not valid after one window"}, int'(valid_out), 0);
        half(lit, lit, 0);
        chk({req, " valid"}, int'(valid_out), 1);
        chk({req, " digit"}, int'(digit_out), exp);
        chk({req, " R8 nomatch clear"}, int'(nomatch_out), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk("R1 digit after reset", int'(digit_out), 0);
        chk("R1 valid after reset", int'(valid_out), 0);
        chk("R1 nomatch after reset", int'(nomatch_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        half(font(0), font(0), 0);

        // R2/R3/R4: ascending sweep including wrap from 9 back to 0.
        for (int d = 1; d <= 9; d++) show_digit(font(d), d, "R3 up");
        show_digit(font(0), 0, "R4 wrap");
        // Descending order forces long searches through the wrap.
        for (int d = 8; d >= 1; d--) show_digit(font(d), d, "R4 down");

        // R10: same digit kept on screen stays valid and unchanged.
        show_digit(font(5), 5, "R10 setup");
        saw_drop = 1'b0; saw_other = 5;
        for (int k = 0; k < 6; k++) half(font(5), font(5), 0);
        chk("R10 valid held", int'(saw_drop), 0);
        chk("R10 digit held", saw_other, 5);

        // R5: skewed segment lines show 8 briefly after each edge.
        show_digit(font(3), 3, "R5 setup");
        saw_drop = 1'b0; saw_other = 3;
        for (int k = 0; k < 8; k++) half(font(3), font(8), SETTLE - 2);
        chk("R5 valid never dropped", int'(saw_drop), 0);
        chk("R5 digit unchanged", saw_other, 3);

        // R7/R8: non-digit glyphs E, H and blank raise nomatch.
        half(7'b1001111, 7'b1001111, 0);
        chk("R7 valid dropped on E", int'(valid_out), 0);
        half(7'b1001111, 7'b1001111, 0);
        chk("R8 nomatch on E", int'(nomatch_out), 1);
        chk("R8 not valid on E", int'(valid_out), 0);
        half(7'b0110111, 7'b0110111, 0);
        half(7'b0110111, 7'b0110111, 0);
        chk("R8 nomatch on H", int'(nomatch_out), 1);
        half(7'b0000000, 7'b0000000, 0);
        half(7'b0000000, 7'b0000000, 0);
        chk("R8 nomatch on blank", int'(nomatch_out), 1);
        chk("R8 not valid on blank", int'(valid_out), 0);
        show_digit(font(7), 7, "R8 clears on digit");

        // R9: tail-less 6 and 9 decode under don't-care tails.
        show_digit(7'b0011111, 6, "R9 six no tail");
        show_digit(7'b1110011, 9, "R9 nine no tail");
        show_digit(font(6), 6, "R9 six tail");
        show_digit(font(9), 9, "R9 nine tail");

        // R1: reset in the middle of a lock.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R1 valid on mid reset", int'(valid_out), 0);
        chk("R1 digit on mid reset", int'(digit_out), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule